// File: doc/BRIEF.md
# Hyperblock Output Commit Unit

This unit sits between the execution array of a block-atomic processor and its architectural register file. An instruction block is launched with a start pulse that carries the number of register outputs the block will produce. While the block runs, producers deliver output writes. Each write names a destination register and carries the static program-order position of the producing instruction within the block. The unit holds these values in a private buffer indexed by register name. Temporaries never reach it, so nothing is written to the register file before the block commits.

The unit does not track instruction completion. It decides commit by counting the distinct outputs it holds. When a taken early-exit branch is reported, the branch position becomes a cut-off. Outputs positioned after it are discarded, both those already held and those still to arrive, and the expected count is replaced by the exit's own count. Once the held count matches the expected count, the buffer is drained into the register file one register per cycle in ascending name order, and a done pulse follows. A flush input drops everything without committing, for misprediction recovery. One block is handled at a time.

Top module: `hb_commit`

## Requirements
- R1: After reset the register-file write enable, the done pulse and the duplicate flag are all low.
- R2: While no block is armed (no start since the last commit or flush), output writes and exit events are ignored. They leave no trace in a later block.
- R3: No register-file write happens until the number of distinct held outputs equals the expected count loaded by start (or replaced by an exit).
- R4: Commit writes one held register per cycle, in strictly ascending register name, with the value that was buffered for it. The done pulse lasts one cycle and comes in the cycle right after the last write. The unit is then idle.
- R5: A kept write to a register name already held raises the duplicate flag for one cycle, in the cycle after the write. The first value is kept, and the repeat does not count toward commit.
- R6: An exit event drops every output whose position is strictly greater than the exit position, both held ones and later arrivals, and replaces the expected count with the exit count.
- R7: Once an exit is taken, a further exit event takes effect only if its position is earlier. A later-positioned one is ignored.
- R8: An output write arriving in the same cycle as an exit event is judged against that exit's position.
- R9: Flush empties the buffer and disarms the unit without any register-file write. The next block starts empty.
- R10: A block started with an expected count of zero produces a done pulse and no register-file write.
- R11: Output writes arriving once the expected count has been reached are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms the unit for a new block (pulse) |
| start_count | input | CW | Expected number of outputs for the block |
| wr_valid | input | 1 | Output write strobe |
| wr_reg | input | RW | Destination register name |
| wr_idx | input | IW | Static program-order position of the producer |
| wr_data | input | DW | Output value |
| exit_valid | input | 1 | Taken early-exit event |
| exit_idx | input | IW | Program-order position of the exit branch |
| exit_count | input | CW | Output count for that exit |
| flush | input | 1 | Discard the block without committing |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | RW | Register-file write address |
| rf_data | output | DW | Register-file write data |
| commit_done | output | 1 | One-cycle pulse after the last commit write |
| dup_err | output | 1 | Duplicate output write flagged |

## Verification
An output write and an early-exit event can land on the same clock edge, and the write must be filtered against the exit that arrives with it, not against the earlier cut-off. The bench drives a taken exit and a write positioned after it in one cycle, then a write positioned before it. It judges the result from the committed register list: the late write must be missing, and commit must fire at the exit's count. A second exit with a later position follows, and the fact that commit still fires at the first exit's count shows the second one was ignored.

// File: rtl/hb_commit.sv
module hb_commit #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int IW   = 6,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_count,
  input  logic          wr_valid,
  input  logic [RW-1:0] wr_reg,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          exit_valid,
  input  logic [IW-1:0] exit_idx,
  input  logic [CW-1:0] exit_count,
  input  logic          flush,
  output logic          rf_we,
  output logic [RW-1:0] rf_addr,
  output logic [DW-1:0] rf_data,
  output logic          commit_done,
  output logic          dup_err
);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_DRAIN} st_t;

  st_t           st;
  logic [NREG-1:0] vld;
  logic [DW-1:0] dat [NREG];
  logic [IW-1:0] pos [NREG];
  logic [CW-1:0] want;
  logic          cut_on;
  logic [IW-1:0] cut_pos;

  logic [CW-1:0] held;
  logic [RW-1:0] sel;
  logic [NREG-1:0] keep, add;

  always_comb begin
    held = '0;
    for (int i = 0; i < NREG; i++) held = held + CW'(vld[i]);
  end

  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--) if (vld[i]) sel = RW'(i);
  end

  wire reach     = (st == S_COLLECT) && (held == want);
  wire open_win  = (st == S_COLLECT) && !reach;
  wire exit_fire = open_win && exit_valid && (!cut_on || exit_idx < cut_pos);
  wire lim_on    = cut_on || exit_fire;
  wire [IW-1:0] lim_pos = exit_fire ? exit_idx : cut_pos;
  wire wr_ok     = open_win && wr_valid && !(lim_on && wr_idx > lim_pos);

  always_comb
    for (int i = 0; i < NREG; i++)
      keep[i] = vld[i] && !(exit_fire && pos[i] > exit_idx);

  wire dup   = wr_ok && keep[wr_reg];
  wire store = wr_ok && !keep[wr_reg];
  assign add = store ? (NREG'(1) << wr_reg) : '0;

  assign rf_we       = (st == S_DRAIN) && (|vld);
  assign rf_addr     = sel;
  assign rf_data     = dat[sel];
  assign commit_done = (st == S_DRAIN) && !(|vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vld     <= '0;
      want    <= '0;
      cut_on  <= 1'b0;
      cut_pos <= '0;
      dup_err <= 1'b0;
    end else begin
      dup_err <= dup && !flush;
      if (flush) begin
        st     <= S_IDLE;
        vld    <= '0;
        cut_on <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st     <= S_COLLECT;
            want   <= start_count;
            cut_on <= 1'b0;
          end
          S_COLLECT: begin
            if (reach) st <= S_DRAIN;
            vld <= keep | add;
            if (exit_fire) begin
              cut_on  <= 1'b1;
              cut_pos <= exit_idx;
              want    <= exit_count;
            end
          end
          S_DRAIN: begin
            if (|vld) vld[sel] <= 1'b0;
            else st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      dat[wr_reg] <= wr_data;
      pos[wr_reg] <= wr_idx;
    end
  end

  // R4
  ascending_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && $past(rf_we) |-> rf_addr > $past(rf_addr));

  // R4
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> st == S_IDLE && !commit_done);

  // R5
  dup_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(wr_valid));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld == '0 && !rf_we);

  // R2
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> vld == '0);

endmodule

// File: tb/hb_commit_test.sv
module hb_commit_test;
  localparam int NREG = 16, DW = 32, IW = 6;
  localparam int RW = $clog2(NREG), CW = $clog2(NREG + 1);

  logic clk = 0, rst_n = 0;
  logic start = 0, wr_valid = 0, exit_valid = 0, flush = 0;
  logic [CW-1:0] start_count = '0, exit_count = '0;
  logic [RW-1:0] wr_reg = '0;
  logic [IW-1:0] wr_idx = '0, exit_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic rf_we, commit_done, dup_err;
  logic [RW-1:0] rf_addr;
  logic [DW-1:0] rf_data;

  hb_commit #(.NREG(NREG), .DW(DW), .IW(IW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
    .exit_valid(exit_valid), .exit_idx(exit_idx), .exit_count(exit_count),
    .flush(flush), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .commit_done(commit_done), .dup_err(dup_err));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;
  int nlog = 0, ndone = 0, done_cyc = 0;
  int log_addr [32];
  int log_data [32];
  int log_cyc  [32];
  int exp_addr [8];
  int exp_data [8];

  always @(negedge clk) begin
    cyc++;
    if (rf_we && nlog < 32) begin
      log_addr[nlog] = int'(rf_addr);
      log_data[nlog] = int'(rf_data);
      log_cyc[nlog]  = cyc;
      nlog++;
    end
    if (commit_done) begin
      ndone++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; ndone = 0;
  endtask

  task automatic begin_blk(input int n);
    start = 1; start_count = CW'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wr(input int r, input int idx, input int d);
    wr_valid = 1; wr_reg = RW'(r); wr_idx = IW'(idx); wr_data = DW'(d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic exit_ev(input int idx, input int n);
    exit_valid = 1; exit_idx = IW'(idx); exit_count = CW'(n);
    @(negedge clk);
    exit_valid = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40 && ndone == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_commit(input string tag, input int n);
    chk(ndone == 1, {tag, " done count"}, ndone, 1);
    chk(nlog == n, {tag, " write count"}, nlog, n);
    for (int i = 0; i < n && i < nlog; i++) begin
      chk(log_addr[i] == exp_addr[i], {tag, " addr"}, log_addr[i], exp_addr[i]);
      chk(log_data[i] == exp_data[i], {tag, " data"}, log_data[i], exp_data[i]);
    end
    if (n > 0 && nlog == n)
      chk(done_cyc == log_cyc[n-1] + 1, {tag, " done timing R4"}, done_cyc, log_cyc[n-1] + 1);
  endtask

  task automatic t_reset();
    chk(!rf_we && !commit_done && !dup_err, "R1 reset outputs", {rf_we, commit_done, dup_err}, 0);
  endtask

  task automatic t_idle_ignore();
    clear_log();
    wr(3, 1, 'h33);
    exit_ev(0, 0);
    repeat (2) @(negedge clk);
    chk(nlog == 0, "R2 idle writes", nlog, 0);
    begin_blk(1);
    wr(5, 3, 'h55);
    wait_done();
    exp_addr[0] = 5; exp_data[0] = 'h55;
    check_commit("R2 idle ignore", 1);
  endtask

  task automatic t_basic();
    clear_log();
    begin_blk(3);
    wr(7, 4, 'hA7);
    wr(2, 1, 'hA2);
    chk(nlog == 0, "R3 no early commit", nlog, 0);
    wr(9, 6, 'hA9);
    wait_done();
    exp_addr[0] = 2; exp_data[0] = 'hA2;
    exp_addr[1] = 7; exp_data[1] = 'hA7;
    exp_addr[2] = 9; exp_data[2] = 'hA9;
    check_commit("R3 R4 basic", 3);
  endtask

  task automatic t_dup();
    clear_log();
    begin_blk(2);
    wr(4, 2, 'hB1);
    chk(dup_err == 0, "R5 first write flag", dup_err, 0);
    wr(4, 3, 'hB2);
    chk(dup_err == 1, "R5 dup flag", dup_err, 1);
    @(negedge clk);
    chk(dup_err == 0, "R5 flag one cycle", dup_err, 0);
    chk(nlog == 0, "R5 dup not counted", nlog, 0);
    wr(1, 0, 'hB3);
    wait_done();
    exp_addr[0] = 1; exp_data[0] = 'hB3;
    exp_addr[1] = 4; exp_data[1] = 'hB1;
    check_commit("R5 dup", 2);
  endtask

  task automatic t_exit();
    clear_log();
    begin_blk(4);
    wr(1, 2, 'hC1);
    wr(2, 7, 'hC2);
    exit_ev(9, 3);
    exit_ev(5, 2);
    wr(3, 12, 'hC3);
    chk(nlog == 0, "R6 late write dropped", nlog, 0);
    wr(4, 4, 'hC4);
    wait_done();
    exp_addr[0] = 1; exp_data[0] = 'hC1;
    exp_addr[1] = 4; exp_data[1] = 'hC4;
    check_commit("R6 R7 exit purge", 2);
  endtask

  task automatic t_same_cycle();
    clear_log();
    begin_blk(3);
    wr(6, 3, 'hD6);
    exit_valid = 1; exit_idx = 8; exit_count = 2;
    wr_valid = 1; wr_reg = 7; wr_idx = 9; wr_data = 'hD7;
    @(negedge clk);
    exit_valid = 0; wr_valid = 0;
    exit_ev(12, 5);
    wr(8, 7, 'hD8);
    wait_done();
    exp_addr[0] = 6; exp_data[0] = 'hD6;
    exp_addr[1] = 8; exp_data[1] = 'hD8;
    check_commit("R8 R7 same cycle", 2);
  endtask

  task automatic t_flush();
    clear_log();
    begin_blk(2);
    wr(1, 0, 'hE1);
    flush = 1;
    @(negedge clk);
    flush = 0;
    repeat (3) @(negedge clk);
    chk(nlog == 0 && ndone == 0, "R9 flush no commit", nlog + ndone, 0);
    begin_blk(1);
    wr(10, 2, 'hEA);
    wait_done();
    exp_addr[0] = 10; exp_data[0] = 'hEA;
    check_commit("R9 after flush", 1);
  endtask

  task automatic t_zero();
    clear_log();
    begin_blk(0);
    wait_done();
    check_commit("R10 zero count", 0);
  endtask

  task automatic t_after_reach();
    clear_log();
    begin_blk(1);
    wr(2, 0, 'hF2);
    wr(3, 1, 'hF3);
    wait_done();
    exp_addr[0] = 2; exp_data[0] = 'hF2;
    check_commit("R11 late write", 1);
    clear_log();
    begin_blk(1);
    wr(5, 0, 'hF5);
    wait_done();
    exp_addr[0] = 5; exp_data[0] = 'hF5;
    check_commit("R11 no residue", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_idle_ignore();
    t_basic();
    t_dup();
    t_exit();
    t_same_cycle();
    t_flush();
    t_zero();
    t_after_reach();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #100us;
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule